// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block is the multiply datapath of a small RISC core. Each operation starts with a one-cycle start strobe that carries an operation code and two 32-bit register operands. Only the low 16 bits of each operand enter the product. A plain multiply, unsigned or signed, returns a 32-bit product for the destination register. A three-step group works on a hidden 32-bit accumulator: the first step loads it with a signed product, the second adds a further signed product to it, and the third copies it out to the destination register.

Every operation takes a fixed number of cycles. When it completes, the block raises a one-cycle done strobe. Operations that write a register also raise the write enable in that same cycle. While an operation is still counting down, the block takes no new start, so the core must wait for done before it issues the next multiply. The register file and the instruction decode sit outside the block.

Top module: `mac_unit`

## Requirements
- R1: Operation code 0 (unsigned multiply) sets `result_o` to the unsigned product of `opa_i[15:0]` and `opb_i[15:0]` and raises `wr_en_o` together with `done_o`. Operand bits 31:16 have no effect.
- R2: Operation code 1 (signed multiply) sets `result_o` to the 32-bit two's-complement product of `opa_i[15:0]` and `opb_i[15:0]`, each taken as a signed 16-bit value, and raises `wr_en_o` together with `done_o`.
- R3: Operation code 2 (load accumulator) loads the accumulator with the signed 16x16 product. Its done cycle has `wr_en_o` low, and `result_o` keeps its earlier value.
- R4: Operation code 3 (accumulate) adds the signed 16x16 product to the accumulator modulo 2^32, with `wr_en_o` low in its done cycle.
- R5: Operation code 4 (read accumulator) sets `result_o` to the accumulator value and raises `wr_en_o` together with `done_o`.
- R6: Codes 0, 1 and 4 complete 3 cycles after the clock edge that samples `start_i`; codes 2 and 3 complete 1 cycle after it. The outputs are registered, so for a start sampled at edge k, `done_o` is high for exactly one cycle after edge k+L-1. A new start may be sampled at the edge that ends that done cycle.
- R7: Codes 0 and 1 set `zero_o` when the product is zero and `neg_o` to product bit 31. Codes 2, 3 and 4 leave both flags unchanged.
- R8: A `start_i` that arrives while an operation is still counting down is ignored: it changes neither the accumulator nor the outputs.
- R9: Synchronous reset clears the accumulator and drives `result_o`, `wr_en_o`, `zero_o`, `neg_o` and `done_o` to 0.
- R10: A start with an operation code of 5, 6 or 7 is ignored. No done follows, and the accumulator does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled when the unit is idle |
| op_i | input | 3 | Operation code (0 to 4 valid) |
| opa_i | input | 32 | First register operand; bits 15:0 are used |
| opb_i | input | 32 | Second register operand; bits 15:0 are used |
| result_o | output | 32 | Value for the destination register |
| wr_en_o | output | 1 | Destination write enable, high only in a done cycle |
| zero_o | output | 1 | Zero flag from the last multiply |
| neg_o | output | 1 | Negative flag from the last multiply |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is a start that lands in the middle of a three-cycle operation and carries an accumulate code. If it were accepted, it would change the accumulator silently, and the only way to see that is a later read-accumulator. The stimulus holds the start strobe high across the busy window of a multiply, with accumulate or load codes on it, and then issues a read-accumulator. It also wraps the accumulator past 2^32 with repeated products of -32768 by -32768. Long random runs with back-to-back starts then hit busy-window starts and invalid codes many more times, and a behavioural model checks every clock.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_UMUL     = 3'd0,
    OP_SMUL     = 3'd1,
    OP_ACC_LOAD = 3'd2,
    OP_ACC_ADD  = 3'd3,
    OP_ACC_READ = 3'd4
  } mac_op_e;

  function automatic logic op_known(input logic [OP_W-1:0] code);
    return code <= OP_ACC_READ;
  endfunction

  function automatic logic op_short(input logic [OP_W-1:0] code);
    return (code == OP_ACC_LOAD) || (code == OP_ACC_ADD);
  endfunction
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int HALF_W = 16,
  parameter int PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  input  logic              signed_i,
  output logic [PROD_W-1:0] p_o
);
  localparam int FULL_W = 2 * HALF_W + 2;

  logic signed [HALF_W:0]   a_ext;
  logic signed [HALF_W:0]   b_ext;
  logic signed [FULL_W-1:0] full;

  always_comb begin
    a_ext = {signed_i & a_i[HALF_W-1], a_i};
    b_ext = {signed_i & b_i[HALF_W-1], b_i};
    full  = FULL_W'(a_ext) * FULL_W'(b_ext);
    p_o   = full[PROD_W-1:0];
  end
endmodule

// File: rtl/mac_sequencer.sv
module mac_sequencer
  import mac_pkg::*;
#(
  parameter int LONG_LAT  = 3,
  parameter int SHORT_LAT = 1,
  parameter int CNT_W     = $clog2(LONG_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  output logic            accept_o,
  output logic            finish_o,
  output logic [OP_W-1:0] fin_op_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  op_q;
  logic [CNT_W-1:0] lat;

  always_comb begin
    lat      = op_short(op_i) ? CNT_W'(SHORT_LAT) : CNT_W'(LONG_LAT);
    accept_o = start_i && op_known(op_i) && (cnt_q == '0);
    finish_o = (accept_o && lat == CNT_W'(1)) || (cnt_q == CNT_W'(1));
    fin_op_o = accept_o ? op_i : op_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      op_q  <= '0;
    end else if (accept_o) begin
      op_q  <= op_i;
      cnt_q <= (lat == CNT_W'(1)) ? '0 : lat - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R8: a busy unit takes no new start
  a_r8_busy_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !accept_o);
  // R6: the countdown falls by exactly one per cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R10: unknown codes are never accepted
  a_r10_unknown_rejected: assert property (@(posedge clk) disable iff (rst)
    !op_known(op_i) |-> !accept_o);
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             add_i,
  input  logic [ACC_W-1:0] value_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (load_i) acc_q <= value_i;
    else if (add_i)  acc_q <= acc_q + value_i;
  end

  assign acc_o = acc_q;

  // R4: accumulation wraps modulo 2^ACC_W
  a_r4_add_wraps: assert property (@(posedge clk) disable iff (rst)
    (add_i && !load_i) |=> (acc_q == $past(acc_q) + $past(value_i)));
  // R8: with no load or add the accumulator holds
  a_r8_acc_holds: assert property (@(posedge clk) disable iff (rst)
    (!add_i && !load_i) |=> $stable(acc_q));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HALF_W    = 16,
  parameter int LONG_LAT  = 3,
  parameter int SHORT_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              done_o
);
  localparam int PROD_W = 2 * HALF_W;

  logic              accept;
  logic              finish;
  logic [OP_W-1:0]   fin_op;
  logic [PROD_W-1:0] prod_now;
  logic [PROD_W-1:0] prod_q;
  logic [DATA_W-1:0] fin_prod;
  logic [DATA_W-1:0] acc;
  logic              acc_load;
  logic              acc_add;

  mac_product #(.HALF_W(HALF_W), .PROD_W(PROD_W)) u_product (
    .a_i      (opa_i[HALF_W-1:0]),
    .b_i      (opb_i[HALF_W-1:0]),
    .signed_i (op_i != OP_UMUL),
    .p_o      (prod_now)
  );

  mac_sequencer #(.LONG_LAT(LONG_LAT), .SHORT_LAT(SHORT_LAT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .accept_o (accept),
    .finish_o (finish),
    .fin_op_o (fin_op)
  );

  always_ff @(posedge clk) begin
    if (rst)         prod_q <= '0;
    else if (accept) prod_q <= prod_now;
  end

  assign fin_prod = DATA_W'(accept ? prod_now : prod_q);
  assign acc_load = finish && (fin_op == OP_ACC_LOAD);
  assign acc_add  = finish && (fin_op == OP_ACC_ADD);

  mac_accum #(.ACC_W(DATA_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .load_i  (acc_load),
    .add_i   (acc_add),
    .value_i (fin_prod),
    .acc_o   (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      zero_o   <= 1'b0;
      neg_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o  <= finish;
      wr_en_o <= 1'b0;
      if (finish) begin
        if (fin_op == OP_UMUL || fin_op == OP_SMUL) begin
          result_o <= fin_prod;
          wr_en_o  <= 1'b1;
          zero_o   <= (fin_prod == '0);
          neg_o    <= fin_prod[DATA_W-1];
        end else if (fin_op == OP_ACC_READ) begin
          result_o <= acc;
          wr_en_o  <= 1'b1;
        end
      end
    end
  end

  // R6: a write only happens in a done cycle
  a_r6_write_in_done: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> done_o);
  // R7: accumulator operations leave the flags alone
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (done_o && !wr_en_o) |-> ($stable(zero_o) && $stable(neg_o)));
  // R7: a zero result cannot be negative
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    zero_o |-> !neg_o);
  // R3: loading the accumulator completes without a register write
  a_r3_load_no_write: assert property (@(posedge clk) disable iff (rst)
    (finish && fin_op == OP_ACC_LOAD) |=> (done_o && !wr_en_o));
  // R5: read-back delivers the accumulator
  a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
    (finish && fin_op == OP_ACC_READ) |=> (wr_en_o && result_o == $past(acc)));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, zero_o, neg_o, done_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .zero_o(zero_o), .neg_o(neg_o), .done_o(done_o)
  );

  // Behavioural reference model
  int          m_left;
  int          m_op;
  logic [31:0] m_a, m_b;
  logic [31:0] m_acc, m_res;
  logic        m_we, m_z, m_n, m_done;
  string       m_tag = "R9";
  string       phase = "R9";

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  function automatic logic [31:0] uprod(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'(a[15:0]) * longint'(b[15:0]);
    return p[31:0];
  endfunction

  function automatic logic [31:0] sprod(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    return p[31:0];
  endfunction

  task automatic complete(input int op, input logic [31:0] a, input logic [31:0] b);
    m_done = 1'b1;
    case (op)
      0: begin m_res = uprod(a, b); m_we = 1'b1; m_z = (m_res == 0); m_n = m_res[31]; m_tag = "R1"; end
      1: begin m_res = sprod(a, b); m_we = 1'b1; m_z = (m_res == 0); m_n = m_res[31]; m_tag = "R2"; end
      2: begin m_acc = sprod(a, b); m_tag = "R3"; end
      3: begin m_acc = m_acc + sprod(a, b); m_tag = "R4"; end
      default: begin m_res = m_acc; m_we = 1'b1; m_tag = "R5"; end
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_op = 0; m_acc = 0; m_res = 0;
      m_we = 0; m_z = 0; m_n = 0; m_done = 0; m_a = 0; m_b = 0;
    end else begin
      m_done = 1'b0;
      m_we   = 1'b0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) complete(m_op, m_a, m_b);
      end else if (start_i && op_i <= 3'd4) begin
        if (op_i == 3'd2 || op_i == 3'd3) complete(int'(op_i), opa_i, opb_i);
        else begin
          m_left = 2; m_op = int'(op_i); m_a = opa_i; m_b = opb_i;
        end
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      vectors++;
      if (done_o !== m_done) begin
        misses++;
        $display("FAIL R6 (%s) done: got %b expected %b", phase, done_o, m_done);
      end
      if (wr_en_o !== m_we) begin
        misses++;
        $display("FAIL %s (%s) wr_en: got %b expected %b", m_tag, phase, wr_en_o, m_we);
      end
      if (result_o !== m_res) begin
        misses++;
        $display("FAIL %s (%s) result: got %h expected %h", m_tag, phase, result_o, m_res);
      end
      if (zero_o !== m_z || neg_o !== m_n) begin
        misses++;
        $display("FAIL R7 (%s) flags z/n: got %b%b expected %b%b", phase, zero_o, neg_o, m_z, m_n);
      end
    end
  end

  task automatic drive(input logic st, input logic [2:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start_i = st; op_i = op; opa_i = a; opb_i = b;
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    drive(1'b1, op, a, b);
    drive(1'b0, 3'd0, 32'hDEAD_BEEF, 32'h1234_5678);
    if (op != 3'd2 && op != 3'd3) begin
      drive(1'b0, 3'd0, '0, '0);
      drive(1'b0, 3'd0, '0, '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R9";                                   // R9 reset state
    repeat (2) drive(1'b0, 3'd0, '0, '0);
    run(3'd4, '0, '0);                              // R9 accumulator cleared

    phase = "R1";                                   // R1 upper bits ignored
    run(3'd0, 32'hABCD_FFFF, 32'h1234_FFFF);
    run(3'd0, 32'hFFFF_0000, 32'h0000_7777);        // R7 zero flag
    phase = "R2";
    run(3'd1, 32'h0000_FFFF, 32'h5555_FFFF);
    run(3'd1, 32'h0000_8000, 32'h0000_7FFF);        // R7 negative
    run(3'd1, 32'h0000_8000, 32'h0000_8000);

    phase = "R3";
    run(3'd2, 32'h0000_FFFE, 32'h0000_0003);
    phase = "R4";
    run(3'd3, 32'h0000_0010, 32'h0000_0010);
    phase = "R5";
    run(3'd4, '0, '0);
    phase = "R4";                                   // wrap past 2^32
    run(3'd2, 32'h0000_8000, 32'h0000_8000);
    for (int i = 0; i < 4; i++) run(3'd3, 32'h0000_8000, 32'h0000_8000);
    run(3'd4, '0, '0);

    phase = "R8";                                   // starts while busy
    drive(1'b1, 3'd0, 32'h0000_0003, 32'h0000_0005);
    drive(1'b1, 3'd3, 32'h0000_7FFF, 32'h0000_7FFF);
    drive(1'b1, 3'd2, 32'h0000_1111, 32'h0000_2222);
    drive(1'b0, 3'd0, '0, '0);
    repeat (2) drive(1'b0, 3'd0, '0, '0);
    run(3'd4, '0, '0);

    phase = "R10";                                  // unknown codes
    for (int c = 5; c < 8; c++) drive(1'b1, 3'(c), 32'h0000_0101, 32'h0000_0202);
    drive(1'b0, 3'd0, '0, '0);
    run(3'd4, '0, '0);

    phase = "R6";                                   // random traffic
    for (int i = 0; i < 4000; i++)
      drive(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), $urandom, $urandom);
    repeat (4) drive(1'b0, 3'd0, '0, '0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule